// File: doc/BRIEF.md
# Bus-to-Register Bridge Across Clock Domains

This block is an AXI4-Lite slave clocked by the processor bus clock. It converts each bus access into one access on a plain register port clocked by an unrelated user clock. The register port has a single word address that both reads and writes use. A write is a one-cycle enable that carries data and byte enables. A read is a one-cycle request that the register logic answers, after any number of cycles, with a valid strobe and data.

The bus side has four separate handshake groups: write address, write data, read address and read response. Captured values stay in bus-clock registers. Each request reaches the register clock as a toggle through a two-flop synchronizer, and each completion returns the same way. Only one access is in flight at a time. When a complete write and a read are both waiting, they are granted in turn.

Top module: `axil_reg_bridge`

## Requirements
- R1: After reset, awReady, wReady and arReady are 1, bValid and rValid are 0, and regWrEn and regRdReq are 0.
- R2: A write drives exactly one regWrEn cycle. In that cycle regAddr is awAddr[15:2], regWrData is wData, and regWrBe is wStrb, where bit n of wStrb qualifies byte n (bits 8n+7:8n).
- R3: The register port never has a write and a read in progress together: regWrEn stays 0 from a regRdReq until its regRdValid.
- R4: regWrEn is never high for two consecutive register-clock cycles.
- R5: A read pulses regRdReq for one cycle with regAddr = arAddr[15:2]. regAddr holds that value until regRdValid, and the regRdData sampled with regRdValid is returned on rData.
- R6: bResp and rResp are always 00 (OKAY), and bValid and rValid stay high until bReady and rReady accept them.
- R7: awReady and wReady are 0 from the capture of the write until its B handshake. arReady is 0 from the capture of the read address until its R handshake.
- R8: When a fully captured write and a read address are pending in the same cycle, the direction not granted last wins. After reset, the write wins.
- R9: Write address and write data may be accepted in either order and in different cycles. No register write starts until both have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| busRstN | input | 1 | Bus-side active-low asynchronous reset |
| awAddr | input | 16 | Write byte address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response accept |
| arAddr | input | 16 | Read byte address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data accept |
| regClk | input | 1 | Register-side clock |
| regRstN | input | 1 | Register-side active-low asynchronous reset |
| regAddr | output | 14 | Shared word address |
| regWrEn | output | 1 | One-cycle write enable |
| regWrData | output | 32 | Write data |
| regWrBe | output | 4 | Write byte enables |
| regRdReq | output | 1 | One-cycle read request |
| regRdValid | input | 1 | Read data valid from register logic |
| regRdData | input | 32 | Read data from register logic |

## Verification
A request is granted one bus clock after its last channel is captured. It then shows up as regWrEn or regRdReq three to four register clocks later, depending on the clock phase. A completion raises bValid or rValid three to four bus clocks after the register side acknowledges it. The clocks are unrelated, so the bench never waits a fixed count. A driver queues the register-side events it expects in grant order, and a register-side monitor pops and compares each event in the cycle it appears. Bus-side results are sampled on the falling edge once the valid handshake is seen. Each wait is bounded by the run watchdog.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;
  // strobes from the bus-side control to the bus-side datapath
  typedef struct packed {
    logic capAw;    // latch write address
    logic capW;     // latch write data and strobes
    logic capAr;    // latch read address
    logic grantWr;  // present write address on the shared address
    logic grantRd;  // present read address on the shared address
    logic ackRd;    // read completion arrived: latch returned data
  } busStrb_t;
endpackage

// File: rtl/axil_bridge_bus_ctrl.sv
module axil_bridge_bus_ctrl
  import axil_bridge_pkg::*;
(
  input  logic     busClk,
  input  logic     busRstN,
  input  logic     awValid,
  input  logic     wValid,
  input  logic     arValid,
  input  logic     bReady,
  input  logic     rReady,
  input  logic     ackTgl,
  output logic     awReady,
  output logic     wReady,
  output logic     arReady,
  output logic     bValid,
  output logic     rValid,
  output logic     reqTgl,
  output logic     reqIsRead,
  output busStrb_t strb
);
  logic awHeld, wHeld, arHeld, wrIssued, rdIssued;
  logic inFlight, lastRead;
  logic ackS1, ackS2, ackPrev;
  logic wrPend, rdPend, ackSeen, bDone, rDone;

  assign awReady = !awHeld;
  assign wReady  = !wHeld;
  assign arReady = !arHeld;

  assign wrPend  = awHeld && wHeld && !wrIssued;
  assign rdPend  = arHeld && !rdIssued;
  assign ackSeen = ackS2 ^ ackPrev;
  assign bDone   = bValid && bReady;
  assign rDone   = rValid && rReady;

  always_comb begin
    strb.capAw   = awValid && !awHeld;
    strb.capW    = wValid && !wHeld;
    strb.capAr   = arValid && !arHeld;
    strb.grantWr = !inFlight && wrPend && (!rdPend || lastRead);
    strb.grantRd = !inFlight && rdPend && (!wrPend || !lastRead);
    strb.ackRd   = ackSeen && reqIsRead;
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      {ackS1, ackS2, ackPrev} <= 3'b000;
    end else begin
      ackS1   <= ackTgl;
      ackS2   <= ackS1;
      ackPrev <= ackS2;
    end
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      awHeld    <= 1'b0;
      wHeld     <= 1'b0;
      arHeld    <= 1'b0;
      wrIssued  <= 1'b0;
      rdIssued  <= 1'b0;
      inFlight  <= 1'b0;
      lastRead  <= 1'b1;
      reqTgl    <= 1'b0;
      reqIsRead <= 1'b0;
      bValid    <= 1'b0;
      rValid    <= 1'b0;
    end else begin
      if (strb.capAw) awHeld <= 1'b1;
      if (strb.capW)  wHeld  <= 1'b1;
      if (strb.capAr) arHeld <= 1'b1;
      if (strb.grantWr || strb.grantRd) begin
        inFlight  <= 1'b1;
        reqIsRead <= strb.grantRd;
        lastRead  <= strb.grantRd;
        reqTgl    <= !reqTgl;
        if (strb.grantWr) wrIssued <= 1'b1;
        if (strb.grantRd) rdIssued <= 1'b1;
      end
      if (ackSeen) begin
        inFlight <= 1'b0;
        if (reqIsRead) rValid <= 1'b1;
        else           bValid <= 1'b1;
      end
      if (bDone) begin
        bValid   <= 1'b0;
        awHeld   <= 1'b0;
        wHeld    <= 1'b0;
        wrIssued <= 1'b0;
      end
      if (rDone) begin
        rValid   <= 1'b0;
        arHeld   <= 1'b0;
        rdIssued <= 1'b0;
      end
    end
  end

  p_bvalid_hold_r6: assert property (@(posedge busClk) disable iff (!busRstN)
    bValid && !bReady |=> bValid);
  p_rvalid_hold_r6: assert property (@(posedge busClk) disable iff (!busRstN)
    rValid && !rReady |=> rValid);
  p_awready_low_r7: assert property (@(posedge busClk) disable iff (!busRstN)
    !awReady && !bDone |=> !awReady);
  p_arready_low_r7: assert property (@(posedge busClk) disable iff (!busRstN)
    !arReady && !rDone |=> !arReady);
endmodule

// File: rtl/axil_bridge_bus_data.sv
module axil_bridge_bus_data
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int WA = ADDR_W - 2,
  localparam int SW = DATA_W / 8
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  busStrb_t          strb,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [SW-1:0]     wStrb,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [DATA_W-1:0] rdHold,
  output logic [WA-1:0]     regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [SW-1:0]     regWrBe,
  output logic [DATA_W-1:0] rData
);
  logic [WA-1:0] awWordQ, arWordQ;
  logic unusedByteBits;

  assign unusedByteBits = ^{awAddr[1:0], arAddr[1:0]};

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      awWordQ   <= '0;
      arWordQ   <= '0;
      regAddr   <= '0;
      regWrData <= '0;
      regWrBe   <= '0;
      rData     <= '0;
    end else begin
      if (strb.capAw)   awWordQ   <= awAddr[ADDR_W-1:2];
      if (strb.capAr)   arWordQ   <= arAddr[ADDR_W-1:2];
      if (strb.capW)    begin regWrData <= wData; regWrBe <= wStrb; end
      if (strb.grantWr) regAddr   <= awWordQ;
      if (strb.grantRd) regAddr   <= arWordQ;
      if (strb.ackRd)   rData     <= rdHold;
    end
  end
endmodule

// File: rtl/axil_bridge_reg_side.sv
module axil_bridge_reg_side #(
  parameter int DATA_W = 32,
  parameter int WA = 14
) (
  input  logic              regClk,
  input  logic              regRstN,
  input  logic              reqTgl,
  input  logic              reqIsRead,
  input  logic [WA-1:0]     watchAddr,
  input  logic              regRdValid,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic              regRdReq,
  output logic              ackTgl,
  output logic [DATA_W-1:0] rdHold
);
  logic reqS1, reqS2, reqPrev, waitRd, reqSeen;

  assign reqSeen = reqS2 ^ reqPrev;

  always_ff @(posedge regClk or negedge regRstN) begin
    if (!regRstN) begin
      {reqS1, reqS2, reqPrev} <= 3'b000;
      regWrEn  <= 1'b0;
      regRdReq <= 1'b0;
      waitRd   <= 1'b0;
      ackTgl   <= 1'b0;
      rdHold   <= '0;
    end else begin
      reqS1    <= reqTgl;
      reqS2    <= reqS1;
      reqPrev  <= reqS2;
      regWrEn  <= 1'b0;
      regRdReq <= 1'b0;
      if (reqSeen) begin
        if (reqIsRead) begin
          regRdReq <= 1'b1;
          waitRd   <= 1'b1;
        end else begin
          regWrEn <= 1'b1;
          ackTgl  <= !ackTgl;
        end
      end
      if (waitRd && regRdValid) begin
        rdHold <= regRdData;
        waitRd <= 1'b0;
        ackTgl <= !ackTgl;
      end
    end
  end

  p_wr_pulse_r4: assert property (@(posedge regClk) disable iff (!regRstN)
    regWrEn |=> !regWrEn);
  p_no_overlap_r3: assert property (@(posedge regClk) disable iff (!regRstN)
    waitRd |-> !regWrEn);
  p_addr_steady_r5: assert property (@(posedge regClk) disable iff (!regRstN)
    waitRd && !regRdValid |=> $stable(watchAddr));
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int WA = ADDR_W - 2,
  localparam int SW = DATA_W / 8
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [SW-1:0]     wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  input  logic              regClk,
  input  logic              regRstN,
  output logic [WA-1:0]     regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic [SW-1:0]     regWrBe,
  output logic              regRdReq,
  input  logic              regRdValid,
  input  logic [DATA_W-1:0] regRdData
);
  busStrb_t          strb;
  logic              reqTgl, reqIsRead, ackTgl;
  logic [DATA_W-1:0] rdHold;

  assign bResp = 2'b00;
  assign rResp = 2'b00;

  axil_bridge_bus_ctrl uCtrl (
    .busClk(busClk), .busRstN(busRstN),
    .awValid(awValid), .wValid(wValid), .arValid(arValid),
    .bReady(bReady), .rReady(rReady), .ackTgl(ackTgl),
    .awReady(awReady), .wReady(wReady), .arReady(arReady),
    .bValid(bValid), .rValid(rValid),
    .reqTgl(reqTgl), .reqIsRead(reqIsRead), .strb(strb)
  );

  axil_bridge_bus_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .busClk(busClk), .busRstN(busRstN), .strb(strb),
    .awAddr(awAddr), .wData(wData), .wStrb(wStrb), .arAddr(arAddr),
    .rdHold(rdHold), .regAddr(regAddr), .regWrData(regWrData),
    .regWrBe(regWrBe), .rData(rData)
  );

  axil_bridge_reg_side #(.DATA_W(DATA_W), .WA(WA)) uReg (
    .regClk(regClk), .regRstN(regRstN),
    .reqTgl(reqTgl), .reqIsRead(reqIsRead), .watchAddr(regAddr),
    .regRdValid(regRdValid), .regRdData(regRdData),
    .regWrEn(regWrEn), .regRdReq(regRdReq),
    .ackTgl(ackTgl), .rdHold(rdHold)
  );
endmodule

// File: tb/axil_reg_bridge_test.sv
module axil_reg_bridge_test;
  localparam int BUS_PERIOD = 10;
  localparam int REG_PERIOD = 14;

  logic busClk = 0, regClk = 0, busRstN = 0, regRstN = 0;
  logic [15:0] awAddr = 0, arAddr = 0;
  logic awValid = 0, wValid = 0, arValid = 0, bReady = 0, rReady = 0;
  logic [31:0] wData = 0, rData, regWrData, regRdData = 0;
  logic [3:0] wStrb = 0, regWrBe;
  logic [1:0] bResp, rResp;
  logic awReady, wReady, bValid, arReady, rValid;
  logic [13:0] regAddr;
  logic regWrEn, regRdReq, regRdValid = 0;

  always #(BUS_PERIOD/2) busClk = !busClk;
  always #(REG_PERIOD/2) regClk = !regClk;

  axil_reg_bridge uut (.*);

  typedef struct { bit rd; logic [13:0] addr; logic [31:0] data; logic [3:0] be; } item_t;
  item_t expQ[$];
  logic [31:0] regMem [16];
  logic [31:0] shadow [16];
  int checks = 0, bad = 0, evCount = 0, rdIdx = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge busClk);
    checks++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    endRun();
  end

  // register-side model and scoreboard monitor
  initial begin
    for (int i = 0; i < 16; i++) regMem[i] = 0;
    forever begin
      @(negedge regClk);
      if (regWrEn) begin
        item_t e;
        evCount++;
        if (expQ.size() == 0) chk(0, "R2 unexpected write", {18'd0, regAddr}, 0);
        else begin
          e = expQ.pop_front();
          chk(!e.rd, "R8 order (write seen)", 1, 0);
          chk(regAddr == e.addr, "R2 addr", {18'd0, regAddr}, {18'd0, e.addr});
          chk(regWrData == e.data, "R2 data", regWrData, e.data);
          chk(regWrBe == e.be, "R2 byte enables", {28'd0, regWrBe}, {28'd0, e.be});
        end
        for (int b = 0; b < 4; b++)
          if (regWrBe[b]) regMem[regAddr[3:0]][8*b +: 8] = regWrData[8*b +: 8];
        @(negedge regClk);
        chk(!regWrEn, "R4 single-cycle write", {31'd0, regWrEn}, 0);
      end else if (regRdReq) begin
        item_t e;
        logic [13:0] a;
        int lat;
        evCount++;
        a = regAddr;
        if (expQ.size() == 0) chk(0, "R5 unexpected read", {18'd0, regAddr}, 0);
        else begin
          e = expQ.pop_front();
          chk(e.rd, "R8 order (read seen)", 0, 1);
          chk(regAddr == e.addr, "R5 addr", {18'd0, regAddr}, {18'd0, e.addr});
        end
        lat = 1 + (rdIdx % 3);
        rdIdx++;
        for (int k = 0; k < lat; k++) begin
          @(negedge regClk);
          chk(regAddr == a, "R5 addr held", {18'd0, regAddr}, {18'd0, a});
          chk(!regWrEn, "R3 no write during read", {31'd0, regWrEn}, 0);
        end
        regRdData = regMem[a[3:0]];
        regRdValid = 1;
        @(negedge regClk);
        regRdValid = 0;
      end
    end
  end

  task automatic doAw(input logic [15:0] a);
    awAddr = a; awValid = 1;
    while (!awReady) @(negedge busClk);
    @(negedge busClk); awValid = 0;
  endtask
  task automatic doW(input logic [31:0] d, input logic [3:0] s);
    wData = d; wStrb = s; wValid = 1;
    while (!wReady) @(negedge busClk);
    @(negedge busClk); wValid = 0;
  endtask
  task automatic doAr(input logic [15:0] a);
    arAddr = a; arValid = 1;
    while (!arReady) @(negedge busClk);
    @(negedge busClk); arValid = 0;
  endtask
  task automatic takeB();
    bReady = 1;
    while (!bValid) @(negedge busClk);
    chk(bResp == 2'b00, "R6 bResp OKAY", {30'd0, bResp}, 0);
    @(negedge busClk); bReady = 0;
  endtask
  task automatic takeR(input logic [31:0] exp);
    rReady = 1;
    while (!rValid) @(negedge busClk);
    chk(rData == exp, "R5 read data", rData, exp);
    chk(rResp == 2'b00, "R6 rResp OKAY", {30'd0, rResp}, 0);
    @(negedge busClk); rReady = 0;
  endtask

  function automatic void pushWr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    expQ.push_back('{rd: 0, addr: a[15:2], data: d, be: s});
    for (int b = 0; b < 4; b++) if (s[b]) shadow[a[5:2]][8*b +: 8] = d[8*b +: 8];
  endfunction
  function automatic void pushRd(input logic [15:0] a);
    expQ.push_back('{rd: 1, addr: a[15:2], data: 0, be: 0});
  endfunction

  initial begin
    logic [31:0] e1, e2;
    int ev0;
    for (int i = 0; i < 16; i++) shadow[i] = 0;
    repeat (3) @(negedge busClk);
    busRstN = 1; regRstN = 1;
    @(negedge busClk);
    // R1 reset state
    chk(awReady && wReady && arReady, "R1 readies", {29'd0, awReady, wReady, arReady}, 7);
    chk(!bValid && !rValid, "R1 valids", {30'd0, bValid, rValid}, 0);
    chk(!regWrEn && !regRdReq, "R1 reg strobes", {30'd0, regWrEn, regRdReq}, 0);

    // R2, R6, R7: plain write, response held back
    pushWr(16'h0010, 32'h11223344, 4'hF);
    fork doAw(16'h0010); doW(32'h11223344, 4'hF); join
    while (!bValid) @(negedge busClk);
    chk(!awReady && !wReady, "R7 write readies low", {30'd0, awReady, wReady}, 0);
    repeat (5) @(negedge busClk);
    chk(bValid, "R6 bValid held", {31'd0, bValid}, 1);
    chk(!awReady, "R7 awReady low until B", {31'd0, awReady}, 0);
    takeB();
    chk(awReady && wReady, "R7 readies back", {30'd0, awReady, wReady}, 3);

    // R9: data first, address later; partial strobes (R2)
    ev0 = evCount;
    pushWr(16'h0014, 32'hAABBCCDD, 4'b0101);
    doW(32'hAABBCCDD, 4'b0101);
    repeat (12) @(negedge busClk);
    chk(evCount == ev0, "R9 no write before address", evCount, ev0);
    doAw(16'h0014);
    takeB();

    // R5, R7: reads with held response
    pushRd(16'h0010);
    doAr(16'h0010);
    while (!rValid) @(negedge busClk);
    chk(!arReady, "R7 arReady low until R", {31'd0, arReady}, 0);
    repeat (4) @(negedge busClk);
    chk(rValid, "R6 rValid held", {31'd0, rValid}, 1);
    takeR(shadow[4]);
    chk(arReady, "R7 arReady back", {31'd0, arReady}, 1);
    pushRd(16'h0014);
    doAr(16'h0014);
    takeR(32'h00BB00DD);

    // R8: last grant was a read, both pending -> write first
    pushWr(16'h0018, 32'hCAFE0001, 4'hF);
    pushRd(16'h0010);
    e1 = shadow[4];
    fork doAw(16'h0018); doW(32'hCAFE0001, 4'hF); doAr(16'h0010); join
    fork takeB(); takeR(e1); join

    // R8: last grant a write, both pending -> read first
    pushWr(16'h001C, 32'h5A5A5A5A, 4'hF);
    doAw(16'h001C); doW(32'h5A5A5A5A, 4'hF); takeB();
    pushRd(16'h0018);
    e2 = shadow[6];
    pushWr(16'h0018, 32'h01020304, 4'b1000);
    fork doAw(16'h0018); doW(32'h01020304, 4'b1000); doAr(16'h0018); join
    fork takeB(); takeR(e2); join
    pushRd(16'h0018);
    doAr(16'h0018);
    takeR(shadow[6]);

    repeat (10) @(negedge busClk);
    chk(expQ.size() == 0, "R3 all events seen", expQ.size(), 0);
    endRun();
  end
endmodule